// File: doc/BRIEF.md
# Debiasing Random Word Collector

This block turns a stream of raw entropy bits into 32-bit random words. A generation request (a one-cycle start pulse) arms the collector. From then on, every raw bit presented with its valid strobe goes through a pair-based debiasing stage, unless that stage is bypassed. The bits that survive are shifted into a word. When the word holds 32 accepted bits, it is published on the output and a sticky completion flag is raised.

With debiasing active, long runs of equal bits can starve the collector. A programmable cycle limit therefore bounds each generation. If the word is not complete when the limit is reached, the collector stops and raises a sticky timeout flag instead. One interrupt line reports either outcome, gated by an enable. Software clears each flag with its own pulse. The entropy source itself lies outside the block.

Top module: `trng_post`

## Requirements
- R1: After reset the output word is zero, and the busy, completion, timeout and interrupt outputs are all low.
- R2: With debiasing bypassed (`vn_en_i` low), each raw bit sampled while busy is accepted as it is. Accepted bits enter the word at bit 0 and shift towards bit 31, so the first accepted bit of a generation ends up in bit 31.
- R3: With debiasing enabled, raw bits are grouped into non-overlapping pairs (first, second). Pair 0,1 yields a 0 and pair 1,0 yields a 1 (the first bit of the pair). Pairs 0,0 and 1,1 yield nothing.
- R4: On the clock edge that accepts the 32nd bit, the assembled word appears on `rnd_word_o`, `done_o` rises and `busy_o` falls. At every other time `rnd_word_o` holds its value.
- R5: With debiasing enabled and a nonzero limit L, a generation still running at the L-th clock edge after its start edge ends on that edge. `tmo_o` rises, `busy_o` falls and the word output is left unchanged. If the word completes on that same edge, completion wins and no timeout is flagged.
- R6: With debiasing bypassed, or with a limit of zero, no timeout ever occurs, however long the generation runs.
- R7: `done_o` and `tmo_o` stay set until their own clear pulse (`clr_done_i`, `clr_tmo_i`). A flag being set and cleared on the same edge stays set.
- R8: `irq_o` is high exactly when `irq_en_i` is high and at least one of `done_o` or `tmo_o` is set.
- R9: A start pulse, even during a running generation, restarts collection from zero bits. It discards any unpaired first bit and restarts the timeout count. A raw bit offered on the start edge is ignored.
- R10: Raw bits are ignored while `raw_valid_i` is low and while no generation is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle generation request |
| vn_en_i | input | 1 | 1 = pair debiasing on, 0 = raw bits accepted directly |
| limit_i | input | TMO_W | Generation cycle limit, 0 = no limit |
| irq_en_i | input | 1 | Interrupt enable |
| clr_done_i | input | 1 | Clears the completion flag |
| clr_tmo_i | input | 1 | Clears the timeout flag |
| raw_bit_i | input | 1 | Raw entropy bit |
| raw_valid_i | input | 1 | Raw bit strobe |
| rnd_word_o | output | WORD_W | Last completed random word |
| busy_o | output | 1 | Generation in progress |
| done_o | output | 1 | Sticky completion flag |
| tmo_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the bound checker checks the following:
- the interrupt never rises without its enable;
- both flags stay set until they are cleared;
- a timeout only follows a cycle with debiasing enabled;
- completion and timeout never begin together;
- the output word changes only when completion is flagged;
- a start always leaves the block busy.

Only the bench scenarios can show the values the block produces:
- the debiased word contents for each pair pattern;
- the exact edge on which a timeout lands, for each small limit;
- the bit ordering in the word;
- that a restart discards partial bits and a dangling pair half.

// File: rtl/trng_post_pkg.sv
package trng_post_pkg;

    typedef struct packed {
        logic half;   // first bit of a pair held
        logic first;  // value of that first bit
    } vn_state_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic tmo;
    } ctl_flags_t;

endpackage

// File: rtl/trng_vn_extract.sv
module trng_vn_extract
    import trng_post_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic vn_en_i,
    input  logic bit_i,
    input  logic valid_i,
    output logic bit_o,
    output logic valid_o
);

    vn_state_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        bit_o   = bit_i;
        valid_o = 1'b0;
        if (restart_i) begin
            st_d = '0;
        end else if (valid_i) begin
            if (!vn_en_i) begin
                valid_o   = 1'b1;
                st_d.half = 1'b0;
            end else if (!st_q.half) begin
                st_d.half  = 1'b1;
                st_d.first = bit_i;
            end else begin
                st_d.half = 1'b0;
                bit_o     = st_q.first;
                valid_o   = (st_q.first != bit_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/trng_word_pack.sv
module trng_word_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              bit_i,
    input  logic              valid_i,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shf;
        logic [CW-1:0]     cnt;
    } pack_state_t;

    pack_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        full_o = 1'b0;
        word_o = {st_q.shf[WORD_W-2:0], bit_i};
        if (restart_i) begin
            st_d = '0;
        end else if (valid_i) begin
            st_d.shf = word_o;
            if (st_q.cnt == LAST) begin
                full_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/trng_gen_timer.sv
module trng_gen_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);

    logic [TMO_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
        if (restart_i)  cnt_d = '0;
        else if (run_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/trng_post.sv
module trng_post
    import trng_post_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              vn_en_i,
    input  logic [TMO_W-1:0]  limit_i,
    input  logic              irq_en_i,
    input  logic              clr_done_i,
    input  logic              clr_tmo_i,
    input  logic              raw_bit_i,
    input  logic              raw_valid_i,
    output logic [WORD_W-1:0] rnd_word_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              tmo_o,
    output logic              irq_o
);

    typedef struct packed {
        ctl_flags_t        fl;
        logic [WORD_W-1:0] word;
    } top_state_t;

    top_state_t st_q, st_d;

    logic              take;
    logic              vn_bit, vn_valid;
    logic              full;
    logic [WORD_W-1:0] next_word;
    logic              run, expire;

    assign take = st_q.fl.busy & raw_valid_i & ~start_i;
    assign run  = st_q.fl.busy & vn_en_i & ~start_i & ~full;

    trng_vn_extract u_vn (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .vn_en_i   (vn_en_i),
        .bit_i     (raw_bit_i),
        .valid_i   (take),
        .bit_o     (vn_bit),
        .valid_o   (vn_valid)
    );

    trng_word_pack #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .bit_i     (vn_bit),
        .valid_i   (vn_valid),
        .full_o    (full),
        .word_o    (next_word)
    );

    trng_gen_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .run_i     (run),
        .limit_i   (limit_i),
        .expire_o  (expire)
    );

    always_comb begin
        st_d = st_q;
        if (clr_done_i) st_d.fl.done = 1'b0;
        if (clr_tmo_i)  st_d.fl.tmo  = 1'b0;
        if (start_i) begin
            st_d.fl.busy = 1'b1;
        end else if (full) begin
            st_d.fl.busy = 1'b0;
            st_d.fl.done = 1'b1;
            st_d.word    = next_word;
        end else if (expire) begin
            st_d.fl.busy = 1'b0;
            st_d.fl.tmo  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rnd_word_o = st_q.word;
    assign busy_o     = st_q.fl.busy;
    assign done_o     = st_q.fl.done;
    assign tmo_o      = st_q.fl.tmo;
    assign irq_o      = irq_en_i & (st_q.fl.done | st_q.fl.tmo);

endmodule

// File: rtl/trng_post_chk.sv
module trng_post_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              vn_en_i,
    input logic              irq_en_i,
    input logic              clr_done_i,
    input logic              clr_tmo_i,
    input logic [WORD_W-1:0] rnd_word_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              tmo_o,
    input logic              irq_o
);

    p_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_done_i) |=> done_o);

    p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_o && !clr_tmo_i) |=> tmo_o);

    p_tmo_vn_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_o) |-> $past(vn_en_i));

    p_single_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(done_o) && $rose(tmo_o)));

    p_word_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rnd_word_o) |-> done_o);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

bind trng_post trng_post_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .vn_en_i    (vn_en_i),
    .irq_en_i   (irq_en_i),
    .clr_done_i (clr_done_i),
    .clr_tmo_i  (clr_tmo_i),
    .rnd_word_o (rnd_word_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .tmo_o      (tmo_o),
    .irq_o      (irq_o)
);

// File: tb/trng_post_tb.sv
module trng_post_tb;

    localparam int W  = 32;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i = 1'b0;
    logic          vn_en_i = 1'b0;
    logic [TW-1:0] limit_i = '0;
    logic          irq_en_i = 1'b1;
    logic          clr_done_i = 1'b0;
    logic          clr_tmo_i = 1'b0;
    logic          raw_bit_i = 1'b0;
    logic          raw_valid_i = 1'b0;
    logic [W-1:0]  rnd_word_o;
    logic          busy_o, done_o, tmo_o, irq_o;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    trng_post #(.WORD_W(W), .TMO_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vn_en_i(vn_en_i),
        .limit_i(limit_i), .irq_en_i(irq_en_i), .clr_done_i(clr_done_i),
        .clr_tmo_i(clr_tmo_i), .raw_bit_i(raw_bit_i), .raw_valid_i(raw_valid_i),
        .rnd_word_o(rnd_word_o), .busy_o(busy_o), .done_o(done_o),
        .tmo_o(tmo_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        raw_valid_i = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        raw_bit_i   = b;
        raw_valid_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_flags();
        raw_valid_i = 1'b0;
        clr_done_i = 1'b1;
        clr_tmo_i  = 1'b1;
        @(negedge clk);
        clr_done_i = 1'b0;
        clr_tmo_i  = 1'b0;
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        logic [31:0] pat;
        logic [31:0] prev;
        int acc;
        logic a, b;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 word", rnd_word_o, 0);
        check("R1 flags", {busy_o, done_o, tmo_o, irq_o}, 0);

        // R2 + R10: bypass, MSB-first, with valid-low garbage cycles
        vn_en_i = 1'b0; limit_i = 16'd3;
        pat = 32'hC3A5_0F96;
        pulse_start();
        for (int i = 31; i >= 0; i--) begin
            if (i % 3 == 0) begin
                raw_bit_i = ~pat[i]; raw_valid_i = 1'b0;
                @(negedge clk);
            end
            if (i == 0) begin
                check("R4 busy before last bit", busy_o, 1);
                clr_done_i = 1'b1;  // R7: set wins over clear
            end
            send_bit(pat[i]);
            clr_done_i = 1'b0;
        end
        raw_valid_i = 1'b0;
        check("R2 bypass word", rnd_word_o, pat);
        check("R4 done set", done_o, 1);
        check("R4 busy cleared", busy_o, 0);
        check("R7 set beats clear", done_o, 1);
        check("R6 no timeout in bypass", tmo_o, 0);
        check("R8 irq on done", irq_o, 1);

        // R10: bits after completion ignored
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        idle(1);
        check("R10 word held when idle", rnd_word_o, pat);
        check("R10 busy stays low", busy_o, 0);

        // R8 enable gating, R7 stickiness
        irq_en_i = 1'b0;
        idle(3);
        check("R8 irq gated", irq_o, 0);
        check("R7 done sticky", done_o, 1);
        irq_en_i = 1'b1;
        clr_done_i = 1'b1; @(negedge clk); clr_done_i = 1'b0;
        check("R7 done cleared", done_o, 0);
        check("R8 irq low after clear", irq_o, 0);

        // R3: all four pair kinds, deterministic
        vn_en_i = 1'b1; limit_i = '0;
        pulse_start();
        for (int g = 0; g < 16; g++) begin
            send_bit(0); send_bit(1);
            send_bit(0); send_bit(0);
            send_bit(1); send_bit(0);
            send_bit(1); send_bit(1);
        end
        raw_valid_i = 1'b0;
        check("R3 pair kinds word", rnd_word_o, 32'h5555_5555);
        check("R3 done", done_o, 1);
        clear_flags();

        // R3 sweep over pseudo-random raw streams, expected computed here
        for (int s = 0; s < 6; s++) begin
            pulse_start();
            exp = '0; acc = 0;
            while (acc < 32) begin
                a = next_rand();
                b = (s % 2 == 1) ? (next_rand() & next_rand()) : next_rand();
                send_bit(a);
                if (a != b) begin
                    exp = {exp[30:0], a};
                    acc++;
                end
                send_bit(b);
            end
            raw_valid_i = 1'b0;
            check("R3 random stream word", rnd_word_o, exp);
            check("R4 random stream done", {busy_o, done_o}, 2'b01);
            clear_flags();
        end

        // R5: exact timeout edge, limits 1..6
        for (int L = 1; L <= 6; L++) begin
            prev = rnd_word_o;
            limit_i = TW'(L);
            pulse_start();
            idle(L - 1);
            check("R5 before limit", {busy_o, tmo_o}, 2'b10);
            idle(1);
            check("R5 timeout flagged", {busy_o, tmo_o, done_o}, 3'b010);
            check("R5 word unchanged", rnd_word_o, prev);
            check("R8 irq on timeout", irq_o, 1);
            idle(2);
            check("R7 tmo sticky", tmo_o, 1);
            clear_flags();
            check("R7 tmo cleared", tmo_o, 0);
        end

        // R5: completion on the limit edge wins
        limit_i = 16'd64;
        pulse_start();
        for (int i = 0; i < 32; i++) begin send_bit(1); send_bit(0); end
        raw_valid_i = 1'b0;
        check("R5 completion wins", {done_o, tmo_o}, 2'b10);
        check("R5 completion word", rnd_word_o, 32'hFFFF_FFFF);
        clear_flags();

        // R6: limit zero never times out
        limit_i = '0;
        pulse_start();
        idle(100);
        check("R6 limit zero", {busy_o, tmo_o}, 2'b10);

        // R9: restart discards count, dangling half and start-edge bit
        for (int i = 0; i < 10; i++) begin send_bit(0); send_bit(1); end
        send_bit(0);                      // dangling first half
        raw_bit_i = 1'b0; raw_valid_i = 1'b1;
        pulse_start();                    // bit on start edge ignored
        for (int i = 0; i < 32; i++) begin
            if (i == 31) check("R9 busy before final pair", busy_o, 1);
            send_bit(1); send_bit(0);
        end
        raw_valid_i = 1'b0;
        check("R9 restart word", rnd_word_o, 32'hFFFF_FFFF);
        check("R9 restart done", done_o, 1);
        clear_flags();

        // R6: bypass ignores small limit over a long run
        vn_en_i = 1'b0; limit_i = 16'd2;
        pulse_start();
        idle(20);
        check("R6 bypass no timeout", {busy_o, tmo_o}, 2'b10);
        for (int i = 0; i < 32; i++) send_bit(i[0]);
        raw_valid_i = 1'b0;
        check("R2 alternating word", rnd_word_o, 32'h5555_5555);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule